// File: doc/BRIEF.md
# Sixteen-Bit Timer with Atomic Byte Access

This block is a 16-bit timer/counter peripheral on an 8-bit CPU register bus. It holds a free-running counter, two compare channels and a capture register. Each 16-bit register appears to the CPU as a low-byte location and a high-byte location. All of them share one 8-bit holding register. Because of that shared register, a 16-bit value always moves in one piece, even though the CPU moves it one byte at a time.

The counter advances on a tick. The tick comes from an internal enable pulse or from rising edges of an external clock pin, as a select input chooses. On every tick each compare channel checks its register against the counter. A hit sets the channel's flag and toggles the channel's waveform output. A rising edge on the capture input stores the counter and raises a flag. When the counter wraps it raises the overflow flag.

A CPU write to the counter blocks compare hits on the next tick, on every channel. This stops a freshly loaded value from raising a false or doubled event.

Top module: `timer16_atomic`

## Requirements
- R1: After reset, every register, the holding byte, the flags and the waveform outputs are zero, and every readable location returns 0x00.
- R2: Byte addresses are: counter low/high at 0/1, channel A at 2/3, channel B at 4/5, capture at 6/7, and flags at 8. A write to any odd (high) address stores the byte only in the shared holding register. A write to an even (low) address loads that register with {holding byte, written byte} in one cycle. The high byte may therefore come from any odd address.
- R3: A read of the counter or capture low byte returns the low byte at once and copies that register's high byte into the holding register. A read of their high byte returns the holding register. A channel high-byte read returns the channel register directly and leaves the holding register unchanged.
- R4: With the select input at 0 the counter adds one on each clock in which the tick input is high. With the select at 1 it adds one on each rising edge of the external pin, with one cycle of latency, and ignores the tick input. A CPU load in the same cycle as a tick wins.
- R5: The counter wraps from 0xFFFF to 0x0000, and that tick sets flag bit 0.
- R6: On a tick where the counter value before the increment equals a channel register, that channel's flag sets (bit 1 for A, bit 2 for B) and its waveform output toggles. Without a hit the waveform holds.
- R7: After a CPU write to the counter, the next tick produces no compare hit on any channel. Later ticks compare normally.
- R8: A rising edge on the capture input stores the counter value of that cycle in the capture register and sets flag bit 3. A held-high input captures once. A capture beats a CPU write to the capture register in the same cycle.
- R9: Flags are sticky. Writing 1 to a bit of address 8 clears it, and writing 0 leaves it. A flag set in the same cycle as its clear stays set. The flags are also driven on an output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (affects only the holding byte) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| tick_in | input | 1 | Internal count enable |
| ext_clk_in | input | 1 | External count pin |
| clk_sel | input | 1 | 0: internal tick, 1: external pin edges |
| capture_in | input | 1 | Capture trigger, rising edge |
| wave_o | output | 2 | Waveform output per compare channel (bit 0 = A) |
| flags_o | output | 4 | Sticky flags: overflow, A, B, capture |

## Verification
Two cases are hard to reach from the ports. The first is a counter load that lands just before a tick on which the counter equals a channel register. The second is a flag clear that lands in the cycle its event fires. Purely random values almost never make the counter equal a channel register. So the random stimulus writes channel and counter bytes near the counter's current value, which makes hits, blocked hits and wraps occur often. Directed sequences pin down both cases exactly, along with a high-byte read that must return a stale snapshot after the counter has moved.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = 2 * BYTE_W;
  localparam int NUM_CMP  = 2;
  localparam int NUM_REG  = NUM_CMP + 2;
  localparam int IDX_W    = $clog2(NUM_REG);
  localparam int ADDR_W   = IDX_W + 2;
  localparam int FLAG_W   = NUM_CMP + 2;

  // register index inside the 16-bit register file
  localparam int REG_CNT  = 0;
  localparam int REG_CMP0 = 1;
  localparam int REG_CAP  = NUM_CMP + 1;

  localparam int ADDR_FLAGS = 2 * NUM_REG;

  // flag bit positions
  localparam int FLG_OVF  = 0;
  localparam int FLG_CMP0 = 1;
  localparam int FLG_CAP  = NUM_CMP + 1;

  function automatic logic [CNT_W-1:0] f_inc(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  function automatic logic f_wraps(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  function automatic logic f_hit(input logic [CNT_W-1:0] cnt,
                                 input logic [CNT_W-1:0] cmp);
    return cnt == cmp;
  endfunction
endpackage

// File: rtl/t16_busif.sv
module t16_busif
  import timer16_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             wr,
  input  logic                             rd,
  input  logic [BYTE_W-1:0]                wdata,
  input  logic [NUM_REG-1:0][CNT_W-1:0]    reg_vals,
  input  logic [FLAG_W-1:0]                flags,
  output logic [BYTE_W-1:0]                rdata,
  output logic [NUM_REG-1:0]               commit,
  output logic [CNT_W-1:0]                 commit_data,
  output logic [FLAG_W-1:0]                flag_clr
);
  logic [BYTE_W-1:0] temp_q;
  logic              is_reg, is_hi, via_temp, snap;
  logic [IDX_W-1:0]  idx;

  assign is_reg   = addr < ADDR_W'(ADDR_FLAGS);
  assign is_hi    = addr[0];
  assign idx      = addr[IDX_W:1];
  assign via_temp = (idx == IDX_W'(REG_CNT)) || (idx == IDX_W'(REG_CAP));
  assign snap     = rd && !wr && is_reg && !is_hi && via_temp;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_FLAGS))
      rdata = BYTE_W'(flags);
    else if (is_reg) begin
      if (!is_hi)        rdata = reg_vals[idx][BYTE_W-1:0];
      else if (via_temp) rdata = temp_q;
      else               rdata = reg_vals[idx][CNT_W-1:BYTE_W];
    end
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_commit
    assign commit[r] = wr && is_reg && !is_hi && (idx == IDX_W'(r));
  end

  assign commit_data = {temp_q, wdata};
  assign flag_clr    = (wr && addr == ADDR_W'(ADDR_FLAGS)) ? wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                  temp_q <= '0;
    else if (wr && is_reg && is_hi) temp_q <= wdata;
    else if (snap)               temp_q <= reg_vals[idx][CNT_W-1:BYTE_W];
  end

  // R2: a high-byte write lands in the holding register only
  a_r2_temp_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_reg && is_hi) |=> temp_q == $past(wdata));
  // R3: a low-byte read of the counter freezes its high byte
  a_r3_counter_snap: assert property (@(posedge clk) disable iff (!rst_n)
    (snap && idx == IDX_W'(REG_CNT)) |=> temp_q == $past(reg_vals[REG_CNT][CNT_W-1:BYTE_W]));
  // R3: other reads leave the holding register alone
  a_r3_temp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !snap) |=> $stable(temp_q));
endmodule

// File: rtl/t16_counter.sv
module t16_counter
  import timer16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             ext_clk_in,
  input  logic             clk_sel,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             wrap,
  output logic             block
);
  logic ext_q, pend_q;

  assign tick  = clk_sel ? (ext_clk_in && !ext_q) : tick_in;
  assign wrap  = tick && f_wraps(cnt);
  assign block = tick && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      ext_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ext_q <= ext_clk_in;
      if (load)      cnt <= load_val;
      else if (tick) cnt <= f_inc(cnt);
      if (load)      pend_q <= 1'b1;
      else if (tick) pend_q <= 1'b0;
    end
  end

  // R4: one step per tick, nothing otherwise, load has priority
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  // R5: wrap lands on zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load) |=> cnt == '0);
endmodule

// File: rtl/t16_cmp.sv
module t16_cmp
  import timer16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  input  logic             block,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cmp,
  output logic             match,
  output logic             wave
);
  assign match = tick && !block && f_hit(cnt, cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp  <= '0;
      wave <= 1'b0;
    end else begin
      if (load)  cmp  <= load_val;
      if (match) wave <= !wave;
    end
  end

  // R6: waveform toggles exactly on hits
  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> wave != $past(wave));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> $stable(wave));
endmodule

// File: rtl/timer16_atomic.sv
module timer16_atomic
  import timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick_in,
  input  logic              ext_clk_in,
  input  logic              clk_sel,
  input  logic              capture_in,
  output logic [1:0]        wave_o,
  output logic [3:0]        flags_o
);
  logic [NUM_REG-1:0][CNT_W-1:0] reg_vals;
  logic [NUM_REG-1:0]            commit;
  logic [CNT_W-1:0]              commit_data;
  logic [FLAG_W-1:0]             flag_clr, flag_set, flags_q;
  logic [CNT_W-1:0]              cnt, cap_q;
  logic                          cnt_tick, cnt_wrap, cnt_block;
  logic [NUM_CMP-1:0]            match, wave;
  logic                          cap_in_q, cap_evt;

  t16_busif u_busif (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .reg_vals(reg_vals), .flags(flags_q), .rdata(bus_rdata),
    .commit(commit), .commit_data(commit_data), .flag_clr(flag_clr)
  );

  t16_counter u_counter (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .ext_clk_in(ext_clk_in),
    .clk_sel(clk_sel), .load(commit[REG_CNT]), .load_val(commit_data),
    .cnt(cnt), .tick(cnt_tick), .wrap(cnt_wrap), .block(cnt_block)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    t16_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .tick(cnt_tick), .block(cnt_block),
      .load(commit[REG_CMP0+i]), .load_val(commit_data),
      .cmp(reg_vals[REG_CMP0+i]), .match(match[i]), .wave(wave[i])
    );
  end

  assign reg_vals[REG_CNT] = cnt;
  assign reg_vals[REG_CAP] = cap_q;
  assign cap_evt = capture_in && !cap_in_q;

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_OVF] = cnt_wrap;
    for (int i = 0; i < NUM_CMP; i++) flag_set[FLG_CMP0+i] = match[i];
    flag_set[FLG_CAP] = cap_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q    <= '0;
      cap_in_q <= 1'b0;
      flags_q  <= '0;
    end else begin
      cap_in_q <= capture_in;
      if (cap_evt)               cap_q <= cnt;
      else if (commit[REG_CAP])  cap_q <= commit_data;
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  assign wave_o  = wave;
  assign flags_o = flags_q;

  // R5: wrap raises the overflow flag
  a_r5_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> flags_q[FLG_OVF]);
  // R7: a blocked tick leaves every waveform alone
  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && cnt_block) |=> $stable(wave));
  // R8: capture stores the counter of the edge cycle
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt)) && flags_q[FLG_CAP]);
  // R9: uncleared flags persist, and a new event beats a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags_q & $past(flags_q & ~flag_clr)) == $past(flags_q & ~flag_clr));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> (flags_q & $past(flag_set)) == $past(flag_set));
endmodule

// File: tb/timer16_atomic_bench.sv
module timer16_atomic_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tick_in = 1'b0, ext_clk_in = 1'b0, clk_sel = 1'b0, capture_in = 1'b0;
  logic [1:0] wave_o;
  logic [3:0] flags_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timer16_atomic u_timer16_atomic (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
    .ext_clk_in(ext_clk_in), .clk_sel(clk_sel), .capture_in(capture_in),
    .wave_o(wave_o), .flags_o(flags_o)
  );

  // reference state built from the requirements
  logic [15:0] m_cnt, m_cap;
  logic [15:0] m_cmp [2];
  logic [7:0]  m_temp;
  logic [3:0]  m_flags;
  logic [1:0]  m_wave;
  logic        m_pend, m_ext_q, m_cap_q;

  always @(posedge clk) begin : model
    logic tk, ce, np;
    logic [3:0] nf;
    logic [1:0] nw;
    logic [15:0] nc, ncap;
    logic [7:0] nt;
    if (!rst_n) begin
      m_cnt <= '0; m_cap <= '0; m_cmp[0] <= '0; m_cmp[1] <= '0; m_temp <= '0;
      m_flags <= '0; m_wave <= '0; m_pend <= 1'b0; m_ext_q <= 1'b0; m_cap_q <= 1'b0;
    end else begin
      tk = clk_sel ? (ext_clk_in && !m_ext_q) : tick_in;
      ce = capture_in && !m_cap_q;
      nf = m_flags;
      if (bus_wr && bus_addr == 4'd8) nf = nf & ~bus_wdata[3:0];
      nw = m_wave;
      if (tk) begin
        if (!m_pend)
          for (int ch = 0; ch < 2; ch++)
            if (m_cnt == m_cmp[ch]) begin nf[ch+1] = 1'b1; nw[ch] = ~nw[ch]; end
        if (m_cnt == 16'hFFFF) nf[0] = 1'b1;
      end
      if (ce) nf[3] = 1'b1;
      nc = tk ? m_cnt + 16'd1 : m_cnt;
      np = tk ? 1'b0 : m_pend;
      nt = m_temp;
      ncap = ce ? m_cnt : m_cap;
      if (bus_wr && bus_addr < 4'd8) begin
        if (bus_addr[0]) nt = bus_wdata;
        else case (bus_addr[2:1])
          2'd0: begin nc = {m_temp, bus_wdata}; np = 1'b1; end
          2'd1: m_cmp[0] <= {m_temp, bus_wdata};
          2'd2: m_cmp[1] <= {m_temp, bus_wdata};
          default: if (!ce) ncap = {m_temp, bus_wdata};
        endcase
      end else if (bus_rd && !bus_wr && bus_addr < 4'd8 && !bus_addr[0]) begin
        if (bus_addr[2:1] == 2'd0) nt = m_cnt[15:8];
        if (bus_addr[2:1] == 2'd3) nt = m_cap[15:8];
      end
      m_cnt <= nc; m_pend <= np; m_temp <= nt; m_cap <= ncap;
      m_flags <= nf; m_wave <= nw; m_ext_q <= ext_clk_in; m_cap_q <= capture_in;
    end
  end

  function automatic logic [7:0] f_read(input logic [3:0] a);
    logic [15:0] v;
    if (a == 4'd8) return {4'b0, m_flags};
    if (a > 4'd8) return 8'h00;
    case (a[2:1])
      2'd0: v = m_cnt;
      2'd1: v = m_cmp[0];
      2'd2: v = m_cmp[1];
      default: v = m_cap;
    endcase
    if (!a[0]) return v[7:0];
    if (a[2:1] == 2'd0 || a[2:1] == 2'd3) return m_temp;
    return v[15:8];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 chk(req, {8'h00, bus_rdata}, {8'h00, exp});
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 8; a++) rd_chk(4'(a), 8'h00, "R1 reset read");
    chk("R1 wave", {14'b0, wave_o}, 16'h0);
    chk("R1 flags", {12'b0, flags_o}, 16'h0);

    // R2 high byte held until low write; R3 direct channel high read
    wr(4'd3, 8'hAB);
    rd_chk(4'd3, 8'h00, "R2 high write not committed");
    rd_chk(4'd2, 8'h00, "R2 low untouched");
    wr(4'd2, 8'hCD);
    rd_chk(4'd3, 8'hAB, "R3 channel high direct");
    rd_chk(4'd2, 8'hCD, "R2 low committed");
    // R2 shared holding byte across addresses
    wr(4'd1, 8'h77);
    wr(4'd4, 8'h88);
    rd_chk(4'd5, 8'h77, "R2 shared holding byte");
    rd_chk(4'd4, 8'h88, "R2 shared low");

    // R3 atomic counter read keeps a stale high byte
    wr(4'd1, 8'h12); wr(4'd0, 8'hFF);
    rd_chk(4'd0, 8'hFF, "R3 counter low");
    ticks(1);
    rd_chk(4'd1, 8'h12, "R3 snapshot high");
    rd_chk(4'd0, 8'h00, "R3 counter low after tick");
    rd_chk(4'd1, 8'h13, "R3 fresh high");

    // R4 internal ticks then external edges
    ticks(5);
    rd_chk(4'd0, 8'h05, "R4 internal count");
    @(negedge clk); clk_sel = 1'b1; tick_in = 1'b1;
    repeat (3) begin
      @(negedge clk); ext_clk_in = 1'b1;
      @(negedge clk); ext_clk_in = 1'b0;
    end
    @(negedge clk); clk_sel = 1'b0; tick_in = 1'b0;
    rd_chk(4'd0, 8'h08, "R4 external edges only");
    rd_chk(4'd1, 8'h13, "R4 external high");

    // R5 wrap and overflow flag
    wr(4'd8, 8'h0F);
    wr(4'd1, 8'hFF); wr(4'd0, 8'hFE);
    ticks(2);
    rd_chk(4'd8, 8'h01, "R5 overflow flag");
    rd_chk(4'd0, 8'h00, "R5 wrapped low");
    rd_chk(4'd1, 8'h00, "R5 wrapped high");

    // R6 compare hit on both channels
    wr(4'd8, 8'h0F);
    wr(4'd3, 8'h00); wr(4'd2, 8'h10);
    wr(4'd5, 8'h00); wr(4'd4, 8'h10);
    wr(4'd1, 8'h00); wr(4'd0, 8'h0E);
    ticks(3);
    rd_chk(4'd8, 8'h06, "R6 compare flags");
    chk("R6 waves toggled", {14'b0, wave_o}, 16'h3);
    rd_chk(4'd0, 8'h11, "R6 counter after hits");

    // R7 load blocks the next tick's hit
    wr(4'd8, 8'h0F);
    wr(4'd1, 8'h00); wr(4'd0, 8'h10);
    ticks(1);
    rd_chk(4'd8, 8'h00, "R7 blocked hit");
    chk("R7 waves held", {14'b0, wave_o}, 16'h3);
    wr(4'd1, 8'h00); wr(4'd0, 8'h0F);
    ticks(2);
    rd_chk(4'd8, 8'h06, "R7 later tick compares");
    chk("R7 waves toggled again", {14'b0, wave_o}, 16'h0);

    // R8 capture on rising edge only
    wr(4'd8, 8'h0F);
    wr(4'd1, 8'h03); wr(4'd0, 8'h00);
    @(negedge clk); capture_in = 1'b1;
    ticks(2);
    @(negedge clk); capture_in = 1'b0;
    rd_chk(4'd6, 8'h00, "R8 capture low");
    rd_chk(4'd7, 8'h03, "R8 capture high");
    rd_chk(4'd8, 8'h08, "R8 capture flag");

    // R9 selective clear and set-beats-clear
    wr(4'd8, 8'h01);
    rd_chk(4'd8, 8'h08, "R9 clear other bit only");
    @(negedge clk); bus_addr = 4'd8; bus_wdata = 8'h08; bus_wr = 1'b1; capture_in = 1'b1;
    @(negedge clk); bus_wr = 1'b0; capture_in = 1'b0;
    rd_chk(4'd8, 8'h08, "R9 set beats clear");
    chk("R9 flags port", {12'b0, flags_o}, 16'h8);
    wr(4'd8, 8'h08);
    rd_chk(4'd8, 8'h00, "R9 cleared");

    // random phase against the reference state
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [3:0] a;
      @(negedge clk);
      chk("R6 random wave", {14'b0, wave_o}, {14'b0, m_wave});
      chk("R9 random flags", {12'b0, flags_o}, {12'b0, m_flags});
      bus_wr = 1'b0; bus_rd = 1'b0;
      op = int'($urandom % 8);
      a = 4'($urandom % 9);
      bus_addr = a;
      if (op == 0) begin
        bus_wr = 1'b1;
        if ($urandom % 2 == 0) bus_wdata = 8'($urandom);
        else if (a[0]) bus_wdata = m_cnt[15:8];
        else bus_wdata = m_cnt[7:0] + 8'($urandom % 6);
      end else if (op == 1) bus_rd = 1'b1;
      tick_in = 1'($urandom % 2);
      if ($urandom % 3 == 0) ext_clk_in = ~ext_clk_in;
      if ($urandom % 50 == 0) clk_sel = ~clk_sel;
      if ($urandom % 4 == 0) capture_in = ~capture_in;
      if (op == 1) #1 chk("R3 random read", {8'h00, bus_rdata}, {8'h00, f_read(a)});
    end
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule